// File: doc/BRIEF.md
# Host Mailbox and Data FIFO Register Window

This block is the host-facing side of a board-level communication channel. It sits in an eight-address I/O window and connects a host bus to two data FIFOs, one for each direction, and two small mailboxes. The host writes outbound data and reads inbound data through a single data port. The port can be used in byte mode or in word mode. The host also reads a level-sensitive status byte, loads a write-only interrupt enable register, and exchanges six-bit mailbox messages. A write to the top address of the window issues a one-cycle reset pulse to the board.

The local processor side pops outbound FIFO entries and pushes inbound entries. It reads the outbound mailbox and writes the inbound mailbox. It also holds the global interrupt enable, which stays off after any reset until the local side turns it on. The FIFO storage is a parameterized synchronous memory. Its entries are as wide as the host data bus.

Top module: `hostmbx_regif`

## Requirements
- R1: After rst_n is released, the status byte reads 0x21, host_irq and board_rst are 0, and host_rdata is 0 while no read is in progress.
- R2: A data-port write (offset 0) in word mode pushes all 16 bits to the outbound FIFO. In byte mode it pushes the low byte with the upper byte zeroed. The local side receives the entries in write order.
- R3: A data-port read (offset 0) pops the inbound FIFO. Word mode returns all 16 bits. Byte mode returns the low byte with bits 15:8 zero. A read of an empty inbound FIFO returns 0 and changes nothing.
- R4: A status read (offset 2) returns a byte whose bits are all levels. Bit 7 means the outbound mailbox has not been read by the board. Bit 6 means the outbound FIFO is full. Bit 5 means the inbound FIFO is empty. Bit 4 means the outbound FIFO holds at least half of DEPTH. Bit 3 is the same threshold for the inbound FIFO. Bit 2 means the inbound mailbox is full. Bit 1 means the inbound FIFO is full. Bit 0 means the outbound FIFO is empty.
- R5: A write to offset 2 loads the interrupt enables. Bit 6 enables inbound mailbox full. Bit 5 enables inbound FIFO full. Bit 3 enables inbound FIFO empty. Bit 2 enables outbound FIFO full. Bit 0 enables outbound FIFO empty. host_irq is high exactly when the global enable is on and some enabled condition is true.
- R6: The global interrupt enable is off after rst_n and after a board reset. It turns on only with a loc_irq_en pulse.
- R7: A host write to offset 3 stores data bits 7:2 in the outbound mailbox and sets status bit 7. A loc_mbx_rd pulse clears status bit 7 but keeps the stored value on loc_mbx_out.
- R8: loc_mbx_wr stores loc_mbx_in and sets status bit 2. Bit 7 of the enable register picks what an offset-3 read returns. When it is 0, the read returns the inbound mailbox shifted left by two and clears status bit 2. When it is 1, the read returns the outbound mailbox shifted left by two and clears nothing.
- R9: When a mailbox is set and cleared in the same cycle, it ends up full.
- R10: A host write to offset 7 raises board_rst for exactly the next cycle. The same write empties both FIFOs, clears both mailboxes, clears the enable register and turns the global enable off.
- R11: Reads of offsets 1, 4, 5, 6 and 7 return 0, and writes to offsets 1, 4, 5 and 6 change no state.
- R12: A push into a full FIFO is dropped, even if a pop happens in the same cycle. The contents and the count stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Offset within the window |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_word | input | 1 | 1 selects word transfers on the data port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid while host_rd is high |
| host_irq | output | 1 | Interrupt request to the host |
| board_rst | output | 1 | One-cycle board reset pulse |
| loc_pop | input | 1 | Pop the outbound FIFO |
| loc_pop_data | output | 16 | Head of the outbound FIFO |
| loc_out_avail | output | 1 | Outbound FIFO holds data |
| loc_push | input | 1 | Push into the inbound FIFO |
| loc_push_data | input | 16 | Inbound entry |
| loc_in_room | output | 1 | Inbound FIFO has a free slot |
| loc_mbx_rd | input | 1 | Board has read the outbound mailbox |
| loc_mbx_out | output | 6 | Outbound mailbox contents |
| loc_mbx_wr | input | 1 | Write the inbound mailbox |
| loc_mbx_in | input | 6 | Inbound mailbox value |
| loc_irq_en | input | 1 | Turn on the global host interrupt enable |

## Verification
Each mailbox has a set side and a clear side that belong to different bus masters, so both can fall in the same cycle. The bench provokes both collisions directly. For the outbound mailbox it drives a host write to offset 3 in the same cycle as loc_mbx_rd. For the inbound mailbox it drives a host read of offset 3 in the same cycle as loc_mbx_wr. Each collision is judged by the data returned in that cycle, and by the status bit and mailbox value read back on the following accesses. A second overlap is a full outbound FIFO that receives a host write while the local side pops. The bench judges this one by the order and number of entries drained afterwards.

// File: rtl/hostmbx_pkg.sv
package hostmbx_pkg;

  localparam int BYTE_W = 8;
  localparam int MBOX_W = 6;

  // window offsets
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd2;
  localparam logic [2:0] OFS_MBOX = 3'd3;
  localparam logic [2:0] OFS_BRST = 3'd7;

  // status byte bit positions
  localparam int ST_OMB_PEND  = 7;
  localparam int ST_OUT_FULL  = 6;
  localparam int ST_IN_EMPTY  = 5;
  localparam int ST_OUT_HALF  = 4;
  localparam int ST_IN_HALF   = 3;
  localparam int ST_IMB_FULL  = 2;
  localparam int ST_IN_FULL   = 1;
  localparam int ST_OUT_EMPTY = 0;

  // enable byte bit positions
  localparam int MK_RDSEL     = 7;
  localparam int MK_IMB       = 6;
  localparam int MK_IN_FULL   = 5;
  localparam int MK_IN_EMPTY  = 3;
  localparam int MK_OUT_FULL  = 2;
  localparam int MK_OUT_EMPTY = 0;

  localparam int N_IRQ_SRC = 5;

  typedef struct packed {
    logic rdsel;
    logic imb;
    logic in_full;
    logic in_empty;
    logic out_full;
    logic out_empty;
  } enab_t;

  function automatic enab_t decode_enab(input logic [BYTE_W-1:0] b);
    enab_t e;
    e.rdsel     = b[MK_RDSEL];
    e.imb       = b[MK_IMB];
    e.in_full   = b[MK_IN_FULL];
    e.in_empty  = b[MK_IN_EMPTY];
    e.out_full  = b[MK_OUT_FULL];
    e.out_empty = b[MK_OUT_EMPTY];
    return e;
  endfunction

endpackage

// File: rtl/hostmbx_fifo.sv
module hostmbx_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 wdata,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty,
  output logic                         half
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok, ptr_en;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign half  = (cnt_q >= CW'(DEPTH / 2));
  assign count = cnt_q;
  assign rdata = mem[rd_ptr_q];

  always_comb begin
    push_ok  = push && !full && !clr;
    pop_ok   = pop && !empty && !clr;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
    ptr_en = clr || push_ok || pop_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (ptr_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= wdata;
  end

endmodule

// File: rtl/hostmbx_mailbox.sv
module hostmbx_mailbox #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         ack,
  output logic [W-1:0] data,
  output logic         pending
);
  logic [W-1:0] data_q, data_d;
  logic         pend_q, pend_d;
  logic         data_en, pend_en;

  always_comb begin
    data_d  = clr ? '0 : wdata;
    data_en = clr || wr;
    // a set in the same cycle as an acknowledge leaves the box full
    if (clr)      pend_d = 1'b0;
    else if (wr)  pend_d = 1'b1;
    else if (ack) pend_d = 1'b0;
    else          pend_d = pend_q;
    pend_en = clr || wr || ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign data    = data_q;
  assign pending = pend_q;

endmodule

// File: rtl/hostmbx_irq.sv
module hostmbx_irq #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         gen_set,
  input  logic [N-1:0] cond,
  input  logic [N-1:0] enab,
  output logic         irq
);
  logic gen_q, gen_d, gen_en;
  logic [N-1:0] hit;

  always_comb begin
    gen_en = clr || gen_set;
    gen_d  = !clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gen_q <= 1'b0;
    else if (gen_en) gen_q <= gen_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    assign hit[i] = cond[i] & enab[i];
  end

  assign irq = gen_q & (|hit);

endmodule

// File: rtl/hostmbx_regif.sv
module hostmbx_regif
  import hostmbx_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_word,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic              host_irq,
  output logic              board_rst,
  input  logic              loc_pop,
  output logic [DW-1:0]     loc_pop_data,
  output logic              loc_out_avail,
  input  logic              loc_push,
  input  logic [DW-1:0]     loc_push_data,
  output logic              loc_in_room,
  input  logic              loc_mbx_rd,
  output logic [MBOX_W-1:0] loc_mbx_out,
  input  logic              loc_mbx_wr,
  input  logic [MBOX_W-1:0] loc_mbx_in,
  input  logic              loc_irq_en
);
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int HI_W   = DW - BYTE_W;
  localparam int MPAD_W = BYTE_W - MBOX_W;

  // access decode
  logic data_wr, data_rd, stat_wr, mbox_wr, mbox_rd, brst_hit;
  assign data_wr  = host_wr && (host_addr == OFS_DATA);
  assign data_rd  = host_rd && (host_addr == OFS_DATA);
  assign stat_wr  = host_wr && (host_addr == OFS_STAT);
  assign mbox_wr  = host_wr && (host_addr == OFS_MBOX);
  assign mbox_rd  = host_rd && (host_addr == OFS_MBOX);
  assign brst_hit = host_wr && (host_addr == OFS_BRST);

  // enable register and reset pulse
  enab_t enab_q, enab_d;
  logic  enab_en;
  logic  brst_q;

  always_comb begin
    enab_en = brst_hit || stat_wr;
    enab_d  = brst_hit ? '0 : decode_enab(host_wdata[BYTE_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       enab_q <= '0;
    else if (enab_en) enab_q <= enab_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brst_q <= 1'b0;
    else        brst_q <= brst_hit;
  end

  // data FIFOs
  logic [DW-1:0] out_wdata, in_head;
  logic [CW-1:0] out_cnt, in_cnt;
  logic          out_full, out_empty, out_half;
  logic          in_full, in_empty, in_half;

  assign out_wdata = host_word ? host_wdata
                               : {{HI_W{1'b0}}, host_wdata[BYTE_W-1:0]};

  hostmbx_fifo #(.W(DW), .DEPTH(DEPTH)) u_out_fifo (
    .clk(clk), .rst_n(rst_n), .clr(brst_hit),
    .push(data_wr), .pop(loc_pop), .wdata(out_wdata),
    .rdata(loc_pop_data), .count(out_cnt),
    .full(out_full), .empty(out_empty), .half(out_half)
  );

  hostmbx_fifo #(.W(DW), .DEPTH(DEPTH)) u_in_fifo (
    .clk(clk), .rst_n(rst_n), .clr(brst_hit),
    .push(loc_push), .pop(data_rd), .wdata(loc_push_data),
    .rdata(in_head), .count(in_cnt),
    .full(in_full), .empty(in_empty), .half(in_half)
  );

  // mailboxes
  logic [MBOX_W-1:0] omb_data, imb_data;
  logic              omb_pend, imb_full;

  hostmbx_mailbox #(.W(MBOX_W)) u_out_mbox (
    .clk(clk), .rst_n(rst_n), .clr(brst_hit),
    .wr(mbox_wr), .wdata(host_wdata[BYTE_W-1:MPAD_W]), .ack(loc_mbx_rd),
    .data(omb_data), .pending(omb_pend)
  );

  hostmbx_mailbox #(.W(MBOX_W)) u_in_mbox (
    .clk(clk), .rst_n(rst_n), .clr(brst_hit),
    .wr(loc_mbx_wr), .wdata(loc_mbx_in), .ack(mbox_rd && !enab_q.rdsel),
    .data(imb_data), .pending(imb_full)
  );

  // status byte
  logic [BYTE_W-1:0] sts;
  always_comb begin
    sts               = '0;
    sts[ST_OMB_PEND]  = omb_pend;
    sts[ST_OUT_FULL]  = out_full;
    sts[ST_IN_EMPTY]  = in_empty;
    sts[ST_OUT_HALF]  = out_half;
    sts[ST_IN_HALF]   = in_half;
    sts[ST_IMB_FULL]  = imb_full;
    sts[ST_IN_FULL]   = in_full;
    sts[ST_OUT_EMPTY] = out_empty;
  end

  // interrupt
  logic [N_IRQ_SRC-1:0] irq_cond, irq_enab;
  assign irq_cond = {imb_full, in_full, in_empty, out_full, out_empty};
  assign irq_enab = {enab_q.imb, enab_q.in_full, enab_q.in_empty,
                     enab_q.out_full, enab_q.out_empty};

  hostmbx_irq #(.N(N_IRQ_SRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .clr(brst_hit), .gen_set(loc_irq_en),
    .cond(irq_cond), .enab(irq_enab), .irq(host_irq)
  );

  // host read mux
  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      case (host_addr)
        OFS_DATA: if (!in_empty)
                    host_rdata = host_word ? in_head
                               : {{HI_W{1'b0}}, in_head[BYTE_W-1:0]};
        OFS_STAT: host_rdata = {{HI_W{1'b0}}, sts};
        OFS_MBOX: host_rdata = {{HI_W{1'b0}},
                                (enab_q.rdsel ? omb_data : imb_data),
                                {MPAD_W{1'b0}}};
        default:  host_rdata = '0;
      endcase
    end
  end

  assign board_rst     = brst_q;
  assign loc_out_avail = !out_empty;
  assign loc_in_room   = !in_full;
  assign loc_mbx_out   = omb_data;

endmodule

// File: rtl/hostmbx_regif_chk.sv
module hostmbx_regif_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    host_addr,
  input logic          host_wr,
  input logic          host_irq,
  input logic          board_rst,
  input logic          loc_mbx_rd,
  input logic          loc_pop,
  input logic [7:0]    sts,
  input logic [CW-1:0] out_cnt,
  input logic [CW-1:0] in_cnt
);

  // R10: pulse lasts one cycle unless another reset write follows
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (board_rst && !(host_wr && host_addr == 3'd7)) |=> !board_rst);

  // R10: pulse only follows a write to offset 7
  a_r10_cause: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst |-> $past(host_wr && host_addr == 3'd7));

  // R10/R6: during the pulse all state is cleared and no interrupt is raised
  a_r10_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst |-> (out_cnt == '0 && in_cnt == '0 && sts == 8'h21 && !host_irq));

  // R7: host mailbox write leaves the pending bit set
  a_r7_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'd3) |=> sts[7]);

  // R7: board read without a host write clears the pending bit
  a_r7_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_mbx_rd && !(host_wr && host_addr == 3'd3)) |=> !sts[7]);

  // R12: a push into a full outbound FIFO without a pop leaves it full
  a_r12_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cnt == CW'(DEPTH) && host_wr && host_addr == 3'd0 && !loc_pop)
      |=> (out_cnt == CW'(DEPTH)));

  // R3: occupancy never exceeds the depth
  a_r3_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cnt <= CW'(DEPTH)) && (in_cnt <= CW'(DEPTH)));

endmodule

bind hostmbx_regif hostmbx_regif_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
  .host_irq(host_irq), .board_rst(board_rst), .loc_mbx_rd(loc_mbx_rd),
  .loc_pop(loc_pop), .sts(sts), .out_cnt(out_cnt), .in_cnt(in_cnt)
);

// File: tb/hostmbx_regif_bench.sv
module hostmbx_regif_bench;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  host_addr;
  logic        host_rd, host_wr, host_word;
  logic [15:0] host_wdata, host_rdata;
  logic        host_irq, board_rst;
  logic        loc_pop, loc_out_avail, loc_push, loc_in_room;
  logic [15:0] loc_pop_data, loc_push_data;
  logic        loc_mbx_rd, loc_mbx_wr, loc_irq_en;
  logic [5:0]  loc_mbx_out, loc_mbx_in;

  int n_tests = 0;
  int n_fail  = 0;

  logic [15:0] q_out[$];
  logic [15:0] q_in[$];
  bit m_opend, m_ifull;

  always #4 clk = ~clk;

  hostmbx_regif u_hostmbx_regif (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_word(host_word), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_irq(host_irq), .board_rst(board_rst),
    .loc_pop(loc_pop), .loc_pop_data(loc_pop_data),
    .loc_out_avail(loc_out_avail), .loc_push(loc_push),
    .loc_push_data(loc_push_data), .loc_in_room(loc_in_room),
    .loc_mbx_rd(loc_mbx_rd), .loc_mbx_out(loc_mbx_out),
    .loc_mbx_wr(loc_mbx_wr), .loc_mbx_in(loc_mbx_in), .loc_irq_en(loc_irq_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_sts(input int on, input int inn,
                                         input bit op, input bit ib);
    logic [7:0] s;
    s[7] = op;
    s[6] = (on == DEPTH);
    s[5] = (inn == 0);
    s[4] = (on >= DEPTH / 2);
    s[3] = (inn >= DEPTH / 2);
    s[2] = ib;
    s[1] = (inn == DEPTH);
    s[0] = (on == 0);
    return s;
  endfunction

  task automatic hw(input logic [2:0] a, input logic [15:0] d, input logic w);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_word = w; host_wr = 1'b1;
    @(posedge clk); #1 host_wr = 1'b0;
  endtask

  task automatic hr(input logic [2:0] a, input logic w, output logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_word = w; host_rd = 1'b1;
    #1 d = host_rdata;
    @(posedge clk); #1 host_rd = 1'b0;
  endtask

  task automatic hpush(input logic [15:0] d, input logic w);
    hw(3'd0, d, w);
    if (q_out.size() < DEPTH) q_out.push_back(w ? d : {8'h00, d[7:0]});
  endtask

  task automatic lpush(input logic [15:0] d);
    @(negedge clk);
    loc_push_data = d; loc_push = 1'b1;
    @(posedge clk); #1 loc_push = 1'b0;
    if (q_in.size() < DEPTH) q_in.push_back(d);
  endtask

  task automatic lpop_chk(input string req);
    @(negedge clk);
    chk(req, {31'd0, loc_out_avail}, {31'd0, q_out.size() > 0});
    if (q_out.size() > 0) chk(req, {16'd0, loc_pop_data}, {16'd0, q_out[0]});
    loc_pop = 1'b1;
    @(posedge clk); #1 loc_pop = 1'b0;
    if (q_out.size() > 0) void'(q_out.pop_front());
  endtask

  task automatic hread_chk(input logic w, input string req);
    logic [15:0] d, e;
    e = 16'h0000;
    if (q_in.size() > 0) e = w ? q_in[0] : {8'h00, q_in[0][7:0]};
    hr(3'd0, w, d);
    chk(req, {16'd0, d}, {16'd0, e});
    if (q_in.size() > 0) void'(q_in.pop_front());
  endtask

  task automatic sts_chk(input string req);
    logic [15:0] d;
    hr(3'd2, 1'b0, d);
    chk(req, {16'd0, d},
        {24'd0, exp_sts(q_out.size(), q_in.size(), m_opend, m_ifull)});
  endtask

  task automatic pulse_gen();
    @(negedge clk); loc_irq_en = 1'b1;
    @(posedge clk); #1 loc_irq_en = 1'b0;
  endtask

  task automatic board_reset();
    hw(3'd7, 16'h00A5, 1'b0);
    q_out.delete(); q_in.delete(); m_opend = 0; m_ifull = 0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0;
    host_addr = '0; host_rd = 0; host_wr = 0; host_word = 0; host_wdata = '0;
    loc_pop = 0; loc_push = 0; loc_push_data = '0;
    loc_mbx_rd = 0; loc_mbx_wr = 0; loc_mbx_in = '0; loc_irq_en = 0;
    m_opend = 0; m_ifull = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    void'($urandom(32'd20240611));

    // R1 reset state
    @(negedge clk);
    chk("R1 irq", {31'd0, host_irq}, 32'd0);
    chk("R1 board_rst", {31'd0, board_rst}, 32'd0);
    chk("R1 rdata idle", {16'd0, host_rdata}, 32'd0);
    sts_chk("R1 status 0x21");

    // R2 byte and word writes
    hpush(16'hBEEF, 1'b0);
    hpush(16'h1234, 1'b1);
    sts_chk("R4 status after two pushes");
    lpop_chk("R2 byte push low lane");
    lpop_chk("R2 word push");
    lpop_chk("R2 drained");

    // R3 inbound reads
    lpush(16'hBEEF);
    lpush(16'h1234);
    hread_chk(1'b0, "R3 byte read upper zero");
    hread_chk(1'b1, "R3 word read");
    hread_chk(1'b1, "R3 empty read returns 0");
    sts_chk("R3 empty read no change");

    // R7 outbound mailbox
    hw(3'd3, 16'h00FF, 1'b0); m_opend = 1;
    sts_chk("R7 pending set");
    chk("R7 value six bits", {26'd0, loc_mbx_out}, 32'h3F);
    @(negedge clk); loc_mbx_rd = 1'b1; @(posedge clk); #1 loc_mbx_rd = 1'b0;
    m_opend = 0;
    sts_chk("R7 pending cleared by board read");
    chk("R7 value kept", {26'd0, loc_mbx_out}, 32'h3F);

    // R8 inbound mailbox and readback select
    @(negedge clk); loc_mbx_in = 6'h15; loc_mbx_wr = 1'b1;
    @(posedge clk); #1 loc_mbx_wr = 1'b0; m_ifull = 1;
    sts_chk("R8 inbound full");
    hw(3'd2, 16'h0080, 1'b0);
    hr(3'd3, 1'b0, d);
    chk("R8 readback outbound", {16'd0, d}, 32'hFC);
    sts_chk("R8 outbound readback does not clear");
    hw(3'd2, 16'h0000, 1'b0);
    hr(3'd3, 1'b0, d); m_ifull = 0;
    chk("R8 inbound value low bits zero", {16'd0, d}, 32'h54);
    sts_chk("R8 inbound cleared by host read");

    // R9 same-cycle set and clear, inbound
    @(negedge clk);
    host_addr = 3'd3; host_rd = 1'b1; loc_mbx_in = 6'h2A; loc_mbx_wr = 1'b1;
    #1 d = host_rdata;
    @(posedge clk); #1 host_rd = 1'b0; loc_mbx_wr = 1'b0; m_ifull = 1;
    chk("R9 collision read returns old value", {16'd0, d}, 32'h54);
    sts_chk("R9 inbound stays full");
    hr(3'd3, 1'b0, d); m_ifull = 0;
    chk("R9 new inbound value", {16'd0, d}, 32'hA8);

    // R9 same-cycle set and clear, outbound
    @(negedge clk);
    host_addr = 3'd3; host_wdata = 16'h00C4; host_wr = 1'b1; loc_mbx_rd = 1'b1;
    @(posedge clk); #1 host_wr = 1'b0; loc_mbx_rd = 1'b0; m_opend = 1;
    sts_chk("R9 outbound stays pending");
    chk("R9 outbound value", {26'd0, loc_mbx_out}, 32'h31);
    @(negedge clk); loc_mbx_rd = 1'b1; @(posedge clk); #1 loc_mbx_rd = 1'b0;
    m_opend = 0;

    // R5 / R6 interrupts
    hw(3'd2, 16'h0001, 1'b0);
    @(negedge clk);
    chk("R6 irq off before global enable", {31'd0, host_irq}, 32'd0);
    pulse_gen();
    @(negedge clk);
    chk("R5 irq on outbound empty", {31'd0, host_irq}, 32'd1);
    hpush(16'h0011, 1'b0);
    @(negedge clk);
    chk("R5 irq follows level", {31'd0, host_irq}, 32'd0);
    hw(3'd2, 16'h0004, 1'b0);
    for (int i = 1; i < DEPTH; i++) hpush(16'h0100 + 16'(i), 1'b1);
    @(negedge clk);
    chk("R5 irq on outbound full", {31'd0, host_irq}, 32'd1);
    sts_chk("R4 full and half bits");
    hpush(16'hDEAD, 1'b1);
    sts_chk("R12 push into full dropped");
    // push during pop at full: push still dropped
    @(negedge clk);
    chk("R12 head before collision", {16'd0, loc_pop_data}, {16'd0, q_out[0]});
    host_addr = 3'd0; host_wdata = 16'hFACE; host_word = 1'b1;
    host_wr = 1'b1; loc_pop = 1'b1;
    @(posedge clk); #1 host_wr = 1'b0; loc_pop = 1'b0;
    void'(q_out.pop_front());
    sts_chk("R12 count after pop with blocked push");
    hw(3'd2, 16'h0040, 1'b0);
    @(negedge clk);
    chk("R5 inbound mailbox enable idle", {31'd0, host_irq}, 32'd0);
    @(negedge clk); loc_mbx_in = 6'h01; loc_mbx_wr = 1'b1;
    @(posedge clk); #1 loc_mbx_wr = 1'b0; m_ifull = 1;
    @(negedge clk);
    chk("R5 irq on inbound mailbox", {31'd0, host_irq}, 32'd1);
    while (q_out.size() > 0) lpop_chk("R12 drain order");
    lpop_chk("R12 no extra entry");

    // R10 board reset
    hw(3'd2, 16'h0001, 1'b0);
    hw(3'd7, 16'h0000, 1'b0);
    chk("R10 pulse high", {31'd0, board_rst}, 32'd1);
    chk("R10 irq cleared", {31'd0, host_irq}, 32'd0);
    q_out.delete(); q_in.delete(); m_opend = 0; m_ifull = 0;
    @(posedge clk); #1;
    chk("R10 pulse one cycle", {31'd0, board_rst}, 32'd0);
    sts_chk("R10 status after board reset");
    pulse_gen();
    @(negedge clk);
    chk("R10 enables cleared", {31'd0, host_irq}, 32'd0);
    hw(3'd2, 16'h0000, 1'b0);

    // R11 dead offsets
    hpush(16'h0077, 1'b0);
    hpush(16'h0078, 1'b0);
    hr(3'd7, 1'b0, d);
    chk("R11 read 7 returns 0", {16'd0, d}, 32'd0);
    hr(3'd1, 1'b1, d);
    chk("R11 read 1 returns 0", {16'd0, d}, 32'd0);
    for (int a = 4; a < 7; a++) begin
      hr(3'(a), 1'b0, d);
      chk("R11 reserved read returns 0", {16'd0, d}, 32'd0);
      hw(3'(a), 16'hFFFF, 1'b1);
    end
    hw(3'd1, 16'hFFFF, 1'b1);
    chk("R11 no reset pulse", {31'd0, board_rst}, 32'd0);
    sts_chk("R11 status unchanged");
    lpop_chk("R11 data intact");
    lpop_chk("R11 data intact");
    lpop_chk("R11 nothing added");

    // random phase
    board_reset();
    for (int it = 0; it < 400; it++) begin
      case ($urandom % 6)
        0: hpush(16'($urandom), 1'b0);
        1: hpush(16'($urandom), 1'b1);
        2: lpop_chk("R2 random drain");
        3: lpush(16'($urandom));
        4: hread_chk(1'($urandom), "R3 random read");
        default: sts_chk("R4 random status");
      endcase
    end
    sts_chk("R4 final status");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule